// File: doc/BRIEF.md
# Dual-Clock Real-Time Counter with Byte Register Access

This block is a 16-bit free-running counter. It counts on a slow counter clock. Software sets it up through a byte-wide register port on the system clock. Writes to the control register and to the count are handed into the counter domain over a toggle handshake, and a busy flag shows while the handoff is in flight. The live count is never read directly. Software raises a self-clearing snapshot request, and the block copies the count into a system-side holding register that the count bytes then return.

The counter wraps to zero after it reaches its period and then raises an overflow flag. It raises a compare flag when the count equals a compare value. Each flag drives an interrupt request output that carries a software-chosen two-bit priority level. Period and compare values are held on the system side. They reach the counter together with the next control or count handoff.

Top module: `rtc_dualclk`

## Requirements
- R1: After reset every register reads 0x00 and both interrupt level outputs are 0.
- R2: Bit 0 of the control register at offset 0 is the run enable. Every write to offset 0 starts a handoff that delivers run enable, period and compare to the counter domain.
- R3: The count holds its value while run enable is 0 or the period is 0.
- R4: While running, a count equal to the period is followed by 0, and the overflow flag (bit 0 of offset 3) is set.
- R5: While running, a count equal to the compare value sets the compare flag (bit 1 of offset 3).
- R6: Bit 0 of offset 1 reads 1 while a handoff is in flight. A count handoff starts only on a write to the count high byte at offset 5. A write to the low byte at offset 4 starts none.
- R7: Writes to control, count high, period high and compare high are ignored while bit 0 of offset 1 is 1.
- R8: Writing 1 to bit 4 of offset 1 requests a count snapshot. The bit reads 1 until the copy is done and then reads 0. Offsets 4 and 5 return the snapshot's low and high bytes.
- R9: Count, period (offsets 6/7) and compare (offsets 8/9) are 16-bit values. A low-byte write goes to a shared temporary byte, and the high-byte write commits both halves.
- R10: Offset 2 bits 3:2 set the compare interrupt level and bits 1:0 set the overflow level. Each irq output equals its level while its flag is set, and is 0 otherwise or when the level is 0.
- R11: Writing 1 to a flag bit at offset 3 clears that flag. Writing 0 leaves it unchanged.
- R12: Bits 7:5 and 3:1 of offset 1 and bits 7:4 of offset 2 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| clk_cnt | input | 1 | Counter clock |
| rst_cnt | input | 1 | Synchronous active-high reset, counter domain |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, one cycle after the address |
| irq_cmp_lvl | output | 2 | Compare interrupt request level |
| irq_ovf_lvl | output | 2 | Overflow interrupt request level |

## Verification
The two functions that meet is a new control write and a count handoff that is still in flight. The bench writes the count high byte and then writes the control register on the very next system cycle, while busy is still high. It passes if the control register still reads its old value after the handoff ends, and if a snapshot shows the loaded count frozen, because the dropped run enable never reached the counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_SYNC  = 4'd1;
  localparam logic [AW-1:0] A_IRQCF = 4'd2;
  localparam logic [AW-1:0] A_FLAGS = 4'd3;
  localparam logic [AW-1:0] A_CNT_L = 4'd4;
  localparam logic [AW-1:0] A_CNT_H = 4'd5;
  localparam logic [AW-1:0] A_PER_L = 4'd6;
  localparam logic [AW-1:0] A_PER_H = 4'd7;
  localparam logic [AW-1:0] A_CMP_L = 4'd8;
  localparam logic [AW-1:0] A_CMP_H = 4'd9;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rtc_cnt_core.sv
module rtc_cnt_core #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_cnt,
  input  logic          rst_cnt,
  input  logic          wr_req_tgl,
  input  logic          wr_is_cnt,
  input  logic          run_en,
  input  logic [CW-1:0] per_val,
  input  logic [CW-1:0] cmp_val,
  input  logic [CW-1:0] cnt_val,
  output logic          wr_ack_tgl,
  input  logic          snap_req_tgl,
  output logic          snap_ack_tgl,
  output logic [CW-1:0] snap_val,
  output logic          ovf_tgl,
  output logic          cmp_tgl,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] per_q,
  output logic          load_evt,
  output logic          run
);
  logic [1:0]    req_s;
  logic          en_q;
  logic [CW-1:0] cmp_q;
  logic          snap_evt;

  rtc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_cnt), .rst(rst_cnt),
    .d({snap_req_tgl, wr_req_tgl}), .q(req_s)
  );

  assign load_evt = req_s[0] ^ wr_ack_tgl;
  assign snap_evt = req_s[1] ^ snap_ack_tgl;
  assign run      = en_q && (per_q != '0);

  always_ff @(posedge clk_cnt) begin
    if (rst_cnt) begin
      wr_ack_tgl   <= 1'b0;
      snap_ack_tgl <= 1'b0;
      snap_val     <= '0;
      ovf_tgl      <= 1'b0;
      cmp_tgl      <= 1'b0;
      cnt_q        <= '0;
      per_q        <= '0;
      cmp_q        <= '0;
      en_q         <= 1'b0;
    end else begin
      if (load_evt) begin
        wr_ack_tgl <= req_s[0];
        en_q       <= run_en;
        per_q      <= per_val;
        cmp_q      <= cmp_val;
        if (wr_is_cnt) cnt_q <= cnt_val;
      end else if (run) begin
        if (cnt_q == per_q) begin
          cnt_q   <= '0;
          ovf_tgl <= ~ovf_tgl;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (cnt_q == cmp_q) cmp_tgl <= ~cmp_tgl;
      end
      if (snap_evt) begin
        snap_ack_tgl <= req_s[1];
        snap_val     <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/rtc_sys_regs.sv
module rtc_sys_regs
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_sys,
  input  logic          rst_sys,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    irq_cmp_lvl,
  output logic [1:0]    irq_ovf_lvl,
  input  logic          wr_ack_tgl,
  input  logic          snap_ack_tgl,
  input  logic [CW-1:0] snap_val,
  input  logic          ovf_tgl,
  input  logic          cmp_tgl,
  output logic          wr_req_tgl,
  output logic          wr_is_cnt,
  output logic          run_en,
  output logic [CW-1:0] per_val,
  output logic [CW-1:0] cmp_val,
  output logic [CW-1:0] cnt_val,
  output logic          snap_req_tgl,
  output logic          busy,
  output logic [3:0]    irq_cfg,
  output logic [1:0]    flags
);
  logic [3:0]    back_s;
  logic [1:0]    evt_d;
  logic          snap_pend;
  logic [DW-1:0] tmp_lo;

  rtc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk(clk_sys), .rst(rst_sys),
    .d({cmp_tgl, ovf_tgl, snap_ack_tgl, wr_ack_tgl}), .q(back_s)
  );

  assign busy      = wr_req_tgl ^ back_s[0];
  assign snap_pend = snap_req_tgl ^ back_s[1];

  always_ff @(posedge clk_sys) begin
    if (rst_sys) begin
      reg_rdata    <= '0;
      irq_cmp_lvl  <= '0;
      irq_ovf_lvl  <= '0;
      wr_req_tgl   <= 1'b0;
      wr_is_cnt    <= 1'b0;
      run_en       <= 1'b0;
      per_val      <= '0;
      cmp_val      <= '0;
      cnt_val      <= '0;
      snap_req_tgl <= 1'b0;
      irq_cfg      <= '0;
      flags        <= '0;
      evt_d        <= '0;
      tmp_lo       <= '0;
    end else begin
      evt_d <= back_s[3:2];
      if (reg_wr && reg_addr == A_FLAGS) flags <= flags & ~reg_wdata[1:0];
      if (back_s[2] ^ evt_d[0]) flags[0] <= 1'b1;
      if (back_s[3] ^ evt_d[1]) flags[1] <= 1'b1;

      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: if (!busy) begin
            run_en     <= reg_wdata[0];
            wr_is_cnt  <= 1'b0;
            wr_req_tgl <= ~wr_req_tgl;
          end
          A_SYNC:  if (reg_wdata[4] && !snap_pend) snap_req_tgl <= ~snap_req_tgl;
          A_IRQCF: irq_cfg <= reg_wdata[3:0];
          A_CNT_L, A_PER_L, A_CMP_L: tmp_lo <= reg_wdata;
          A_CNT_H: if (!busy) begin
            cnt_val    <= {reg_wdata, tmp_lo};
            wr_is_cnt  <= 1'b1;
            wr_req_tgl <= ~wr_req_tgl;
          end
          A_PER_H: if (!busy) per_val <= {reg_wdata, tmp_lo};
          A_CMP_H: if (!busy) cmp_val <= {reg_wdata, tmp_lo};
          default: ;
        endcase
      end

      case (reg_addr)
        A_CTRL:  reg_rdata <= {7'b0, run_en};
        A_SYNC:  reg_rdata <= {3'b0, snap_pend, 3'b0, busy};
        A_IRQCF: reg_rdata <= {4'b0, irq_cfg};
        A_FLAGS: reg_rdata <= {6'b0, flags};
        A_CNT_L: reg_rdata <= snap_val[7:0];
        A_CNT_H: reg_rdata <= snap_val[15:8];
        A_PER_L: reg_rdata <= per_val[7:0];
        A_PER_H: reg_rdata <= per_val[15:8];
        A_CMP_L: reg_rdata <= cmp_val[7:0];
        A_CMP_H: reg_rdata <= cmp_val[15:8];
        default: reg_rdata <= '0;
      endcase

      irq_cmp_lvl <= flags[1] ? irq_cfg[3:2] : 2'b00;
      irq_ovf_lvl <= flags[0] ? irq_cfg[1:0] : 2'b00;
    end
  end
endmodule

// File: rtl/rtc_dualclk.sv
module rtc_dualclk
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_sys,
  input  logic          rst_sys,
  input  logic          clk_cnt,
  input  logic          rst_cnt,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    irq_cmp_lvl,
  output logic [1:0]    irq_ovf_lvl
);
  logic          wr_req_tgl, wr_ack_tgl, wr_is_cnt, run_en;
  logic          snap_req_tgl, snap_ack_tgl, ovf_tgl, cmp_tgl;
  logic [CW-1:0] per_val, cmp_val, cnt_val, snap_val, cnt_q, per_q;
  logic          busy, load_evt, run;
  logic [3:0]    irq_cfg;
  logic [1:0]    flags;

  rtc_sys_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_sys(clk_sys), .rst_sys(rst_sys),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_cmp_lvl(irq_cmp_lvl), .irq_ovf_lvl(irq_ovf_lvl),
    .wr_ack_tgl(wr_ack_tgl), .snap_ack_tgl(snap_ack_tgl), .snap_val(snap_val),
    .ovf_tgl(ovf_tgl), .cmp_tgl(cmp_tgl),
    .wr_req_tgl(wr_req_tgl), .wr_is_cnt(wr_is_cnt), .run_en(run_en),
    .per_val(per_val), .cmp_val(cmp_val), .cnt_val(cnt_val),
    .snap_req_tgl(snap_req_tgl), .busy(busy), .irq_cfg(irq_cfg), .flags(flags)
  );

  rtc_cnt_core #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk_cnt(clk_cnt), .rst_cnt(rst_cnt),
    .wr_req_tgl(wr_req_tgl), .wr_is_cnt(wr_is_cnt), .run_en(run_en),
    .per_val(per_val), .cmp_val(cmp_val), .cnt_val(cnt_val),
    .wr_ack_tgl(wr_ack_tgl), .snap_req_tgl(snap_req_tgl),
    .snap_ack_tgl(snap_ack_tgl), .snap_val(snap_val),
    .ovf_tgl(ovf_tgl), .cmp_tgl(cmp_tgl),
    .cnt_q(cnt_q), .per_q(per_q), .load_evt(load_evt), .run(run)
  );
endmodule

// File: rtl/rtc_dualclk_chk.sv
module rtc_dualclk_chk
  import rtc_pkg::*;
(
  input logic          clk_sys,
  input logic          rst_sys,
  input logic          clk_cnt,
  input logic          rst_cnt,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_rdata,
  input logic          busy,
  input logic          run_en,
  input logic [1:0]    flags,
  input logic [1:0]    irq_cmp_lvl,
  input logic [1:0]    irq_ovf_lvl,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_q,
  input logic          load_evt,
  input logic          run
);
  AST_SYNC_RSVD_ZERO: assert property (@(posedge clk_sys) disable iff (rst_sys)
    (!$past(rst_sys) && $past(reg_addr) == A_SYNC) |-> ((reg_rdata & 8'hEE) == 8'h00)); // R12

  AST_BUSY_DROPS_CTRL: assert property (@(posedge clk_sys) disable iff (rst_sys)
    (busy && reg_wr && reg_addr == A_CTRL) |=> $stable(run_en)); // R7

  AST_CMP_IRQ_NEEDS_FLAG: assert property (@(posedge clk_sys) disable iff (rst_sys)
    (irq_cmp_lvl != 2'b00) |-> $past(flags[1])); // R10

  AST_OVF_IRQ_NEEDS_FLAG: assert property (@(posedge clk_sys) disable iff (rst_sys)
    (irq_ovf_lvl != 2'b00) |-> $past(flags[0])); // R10

  AST_STOPPED_HOLDS: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
    (!run && !load_evt) |=> $stable(cnt_q)); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
    (run && !load_evt && cnt_q == per_q) |=> (cnt_q == '0)); // R4
endmodule

bind rtc_dualclk rtc_dualclk_chk u_chk (
  .clk_sys(clk_sys), .rst_sys(rst_sys), .clk_cnt(clk_cnt), .rst_cnt(rst_cnt),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .busy(busy), .run_en(run_en), .flags(flags),
  .irq_cmp_lvl(irq_cmp_lvl), .irq_ovf_lvl(irq_ovf_lvl),
  .cnt_q(cnt_q), .per_q(per_q), .load_evt(load_evt), .run(run)
);

// File: tb/test_rtc_dualclk.sv
module test_rtc_dualclk;
  logic       clk_sys = 1'b0, clk_cnt = 1'b0;
  logic       rst_sys = 1'b1, rst_cnt = 1'b1;
  logic [3:0] reg_addr = 4'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] irq_cmp_lvl, irq_ovf_lvl;
  int n_chk = 0, n_fail = 0;

  always #10 clk_sys = ~clk_sys;
  always #42 clk_cnt = ~clk_cnt;

  rtc_dualclk i_rtc_dualclk (
    .clk_sys(clk_sys), .rst_sys(rst_sys), .clk_cnt(clk_cnt), .rst_cnt(rst_cnt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_cmp_lvl(irq_cmp_lvl), .irq_ovf_lvl(irq_ovf_lvl)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_sys);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk_sys);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_sys);
    reg_addr = a;
    @(posedge clk_sys);
    @(negedge clk_sys);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(4'd1, s);
      if ((s & 8'h11) == 8'h00) break;
    end
  endtask

  task automatic snapshot(output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'd1, 8'h10);
    wait_idle();
    rd(4'd4, lo);
    rd(4'd5, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], d);
      check("R1 reset read", d, 0);
    end
    check("R1 irq cmp", irq_cmp_lvl, 0);
    check("R1 irq ovf", irq_ovf_lvl, 0);
  endtask

  task automatic t_lohi();
    logic [7:0] d;
    wr(4'd6, 8'h05);
    rd(4'd6, d);
    check("R9 period lo held in temp", d, 0);
    wr(4'd7, 8'h00);
    rd(4'd6, d);
    check("R9 period committed lo", d, 8'h05);
    wr(4'd4, 8'h02);
    rd(4'd1, d);
    check("R6 low byte starts no handoff", d, 0);
    wr(4'd5, 8'h00);
    rd(4'd1, d);
    check("R6 busy after high byte", d, 1);
    wait_idle();
    rd(4'd1, d);
    check("R6 busy clears", d, 0);
  endtask

  task automatic t_run();
    logic [15:0] a, b;
    logic [7:0] d;
    wr(4'd6, 8'h00); wr(4'd7, 8'h00);
    wr(4'd0, 8'h01);
    wait_idle();
    snapshot(a);
    repeat (100) @(posedge clk_sys);
    snapshot(b);
    check("R3 zero period holds count", b, a);
    wr(4'd6, 8'h09); wr(4'd7, 8'h00);
    wr(4'd8, 8'h03); wr(4'd9, 8'h00);
    wr(4'd0, 8'h01);
    wait_idle();
    rd(4'd0, d);
    check("R2 run enable reads back", d, 1);
    repeat (200) @(posedge clk_sys);
    wr(4'd1, 8'h10);
    rd(4'd1, d);
    check("R8 request bit high while copying", d & 8'h10, 8'h10);
    wait_idle();
    rd(4'd1, d);
    check("R8 request bit self-clears", d, 0);
    snapshot(a);
    check("R4 count stays within period", int'(a <= 16'd9), 1);
    snapshot(b);
    check("R2 counter advancing", int'(a != b), 1);
    rd(4'd3, d);
    check("R4 R5 both flags set", d, 8'h03);
    wr(4'd0, 8'h00);
    wait_idle();
    repeat (20) @(posedge clk_sys);
    snapshot(a);
    repeat (100) @(posedge clk_sys);
    snapshot(b);
    check("R3 disabled holds count", b, a);
    wr(4'd3, 8'h01);
    rd(4'd3, d);
    check("R11 clear overflow only", d, 8'h02);
    wr(4'd3, 8'h00);
    rd(4'd3, d);
    check("R11 zero write keeps flag", d, 8'h02);
    wr(4'd3, 8'h02);
    rd(4'd3, d);
    check("R11 clear compare", d, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    logic [7:0] d;
    wr(4'd4, 8'h34);
    wr(4'd5, 8'h12);
    wr(4'd0, 8'h01);
    wait_idle();
    rd(4'd0, d);
    check("R7 control write during busy dropped", d, 0);
    snapshot(v);
    check("R7 R9 loaded count frozen", v, 16'h1234);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    wait_idle();
    wr(4'd0, 8'h01);
    wait_idle();
    repeat (150) @(posedge clk_sys);
    wr(4'd0, 8'h00);
    wait_idle();
    repeat (20) @(posedge clk_sys);
    check("R10 level 0 gives no cmp irq", irq_cmp_lvl, 0);
    check("R10 level 0 gives no ovf irq", irq_ovf_lvl, 0);
    wr(4'd2, 8'hFE);
    rd(4'd2, d);
    check("R12 irq cfg upper bits read 0", d, 8'h0E);
    check("R10 cmp level out", irq_cmp_lvl, 3);
    check("R10 ovf level out", irq_ovf_lvl, 2);
    wr(4'd1, 8'hEE);
    rd(4'd1, d);
    check("R12 sync reserved bits read 0", d, 0);
    wr(4'd3, 8'h01);
    repeat (2) @(negedge clk_sys);
    check("R10 ovf irq drops with flag", irq_ovf_lvl, 0);
    check("R10 cmp irq stays", irq_cmp_lvl, 3);
    wr(4'd2, 8'h00);
    repeat (2) @(negedge clk_sys);
    check("R10 cmp level 0 disables", irq_cmp_lvl, 0);
  endtask

  initial begin
    repeat (10) @(posedge clk_sys);
    @(negedge clk_sys);
    rst_sys = 1'b0; rst_cnt = 1'b0;
    t_reset();
    t_lohi();
    t_run();
    t_busy_ignore();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_sys);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule